// File: doc/BRIEF.md
# NAND Page Hamming ECC Engine

This block protects a 2 kB NAND page with a Hamming code that corrects one bit and detects two bit errors. It keeps one code per 512-byte sector. The page is fed in as a byte stream. In encode mode the engine reads the 2048 data bytes and then sends out the four sector codes, 3 bytes each, in sector order. The writer places these 12 bytes in the last 12 bytes of the 2112-byte page. The 52 spare bytes in front of them belong to other software and are never touched.

In check mode the engine reads the whole page as it comes back from flash: the data bytes, then the 52 free spare bytes, which it discards, then the 12 stored code bytes. For each sector it rebuilds the code and compares it with the stored one. It then gives one status strobe per sector. A correctable error comes with the exact byte offset and bit index, so that software can repair the page before a copy-back writes it again. Sequencing flash commands and applying the repair are done outside this block.

Both byte streams use valid/ready. A byte moves only in a cycle where valid and ready are both high. The engine holds `in_ready_o` low whenever it cannot take a byte: while idle, while emitting codes, and in any cycle where `start_i` is high. When the sink holds `out_ready_i` low, the engine holds `out_valid_o` and `out_data_o` steady until the sink accepts the byte. The status strobe has no handshake.

Top module: `ecc_nand_page_hamming`

## Requirements
- R1: After reset, `in_ready_o`, `out_valid_o` and `stat_valid_o` are low until the next `start_i`.
- R2: Each sector code has 2·ABITS+6 bits, built as complementary pairs. Bit 2j (2j+1) is the XOR of every data bit whose byte address has bit j clear (set), for j < ABITS. Bit 2·ABITS+2c (+1) is the XOR of every data bit whose bit index has bit c clear (set), for c < 3. Code byte k holds code bits 8k+7..8k. Padding bits above the code are zero on output and ignored on check.
- R3: In encode mode (`mode_i`=0 at start), the first code byte is offered in the cycle after the last data byte is accepted. After that come SECTORS×CB code bytes, sector 0 first and byte 0 first within a sector. The engine then goes idle.
- R4: In check mode (`mode_i`=1 at start), the engine takes the data bytes, then SPARE_SKIP bytes whose values have no effect on any status, then the code bytes in the same order as R3.
- R5: If the stored code equals the recomputed code, the sector status is 0 (clean).
- R6: Exactly one flipped data bit in a sector gives status 1 (fixable), with `stat_offset_o` equal to its byte offset in the sector and `stat_bit_o` equal to its bit index (0 = LSB).
- R7: Exactly one flipped bit in a sector's stored code gives status 2 (code damaged).
- R8: Any two flipped bits in a sector, whether data, code or a mix, give status 3 (uncorrectable).
- R9: `stat_valid_o` pulses for one cycle, in the cycle after each sector's last code byte is accepted, with `stat_sector_o` = sector number. It pulses exactly once per sector per check page and never in encode mode.
- R10: A `start_i` in the middle of a page (or during emission) drops all partial results. The page that follows gives exactly its own four statuses.
- R11: No byte is accepted in a cycle where `start_i` is high. A stalled output byte stays valid and unchanged until it is taken.
- R12: `stat_offset_o` and `stat_bit_o` are zero whenever the status is not 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start-of-page pulse; restarts the engine |
| mode_i | input | 1 | 0 = encode, 1 = check; sampled with `start_i` |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte |
| in_ready_o | output | 1 | Engine accepts the input byte |
| out_valid_o | output | 1 | Code byte valid (encode mode) |
| out_data_o | output | 8 | Code byte |
| out_ready_i | input | 1 | Sink accepts the code byte |
| stat_valid_o | output | 1 | Sector status strobe |
| stat_code_o | output | 2 | 0 clean, 1 fixable, 2 code damaged, 3 uncorrectable |
| stat_sector_o | output | log2(SECTORS) | Sector the status belongs to |
| stat_offset_o | output | log2(SECTOR_BYTES) | Byte offset of a fixable error |
| stat_bit_o | output | 3 | Bit index of a fixable error |

## Verification
Two events can land in the same cycle.

The first is a start pulse while a byte is already on offer. The bench does this on every page, because the previous byte stays driven with valid high as `start_i` rises. It also forces a restart part way through a page and during a stalled emission. The bench judges the result through the statuses of the following page: if the stray byte were taken, the byte alignment would shift and every sector status would come out wrong.

The second is the status strobe of sector n arriving in the cycle that accepts the first code byte of sector n+1. Code bytes stream back to back with occasional gaps. The bench sweeps every single data bit, every code bit, every pair of bits in one sector, and data-plus-code pairs. Each page's four statuses are compared with values worked out from the bit positions.

// File: rtl/ecc_nand_pkg.sv
package ecc_nand_pkg;

  typedef enum logic [1:0] {
    ST_CLEAN   = 2'd0,
    ST_FIXABLE = 2'd1,
    ST_CODE    = 2'd2,
    ST_FATAL   = 2'd3
  } ecc_stat_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_DATA = 3'd1,
    PH_SKIP = 3'd2,
    PH_CODE = 3'd3,
    PH_EMIT = 3'd4
  } ecc_phase_e;

  // Bits of a byte whose index has bit c set.
  function automatic logic [7:0] col_mask(input int c);
    logic [7:0] m;
    for (int b = 0; b < 8; b++) m[b] = ((b >> c) & 1) == 1;
    return m;
  endfunction

endpackage

// File: rtl/ecc_sector_acc.sv
module ecc_sector_acc
  import ecc_nand_pkg::*;
#(
  parameter int ABITS = 9,
  parameter int CW    = 2 * ABITS + 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [ABITS-1:0] addr_i,
  input  logic [7:0]       data_i,
  output logic [CW-1:0]    acc_next_o
);

  logic [CW-1:0] acc_q;
  logic [CW-1:0] contrib;
  logic          byte_par;

  assign byte_par = ^data_i;

  // Line parities: whole-byte parity lands in the half selected by each address bit.
  for (genvar j = 0; j < ABITS; j++) begin : g_line
    assign contrib[2*j]   = addr_i[j] ? 1'b0 : byte_par;
    assign contrib[2*j+1] = addr_i[j] ? byte_par : 1'b0;
  end

  // Column parities: split the byte by each bit of the bit index.
  for (genvar c = 0; c < 3; c++) begin : g_col
    assign contrib[2*ABITS+2*c]   = ^(data_i & ~col_mask(c));
    assign contrib[2*ABITS+2*c+1] = ^(data_i &  col_mask(c));
  end

  assign acc_next_o = acc_q ^ (en_i ? contrib : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (en_i)   acc_q <= acc_next_o;
  end

endmodule

// File: rtl/ecc_syn_classify.sv
module ecc_syn_classify
  import ecc_nand_pkg::*;
#(
  parameter int ABITS = 9,
  parameter int CW    = 2 * ABITS + 6
) (
  input  logic [CW-1:0]    syn_i,
  output logic [1:0]       stat_o,
  output logic [ABITS-1:0] off_o,
  output logic [2:0]       bit_o
);

  localparam int NPAIR = ABITS + 3;

  logic [NPAIR-1:0] pair_one;
  logic [ABITS-1:0] off_raw;
  logic [2:0]       bit_raw;
  ecc_stat_e        stat;

  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    assign pair_one[i] = syn_i[2*i] ^ syn_i[2*i+1];
  end
  for (genvar j = 0; j < ABITS; j++) begin : g_off
    assign off_raw[j] = syn_i[2*j+1];
  end
  for (genvar c = 0; c < 3; c++) begin : g_bit
    assign bit_raw[c] = syn_i[2*ABITS+2*c+1];
  end

  always_comb begin
    if (syn_i == '0)          stat = ST_CLEAN;
    else if (&pair_one)       stat = ST_FIXABLE;
    else if ($onehot(syn_i))  stat = ST_CODE;
    else                      stat = ST_FATAL;
  end

  assign stat_o = stat;
  assign off_o  = (stat == ST_FIXABLE) ? off_raw : '0;
  assign bit_o  = (stat == ST_FIXABLE) ? bit_raw : '0;

endmodule

// File: rtl/ecc_nand_page_hamming.sv
module ecc_nand_page_hamming
  import ecc_nand_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int SECTORS      = 4,
  parameter int SPARE_SKIP   = 52,
  localparam int ABITS = $clog2(SECTOR_BYTES),
  localparam int SECW  = $clog2(SECTORS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic             in_valid_i,
  input  logic [7:0]       in_data_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  output logic [7:0]       out_data_o,
  input  logic             out_ready_i,
  output logic             stat_valid_o,
  output logic [1:0]       stat_code_o,
  output logic [SECW-1:0]  stat_sector_o,
  output logic [ABITS-1:0] stat_offset_o,
  output logic [2:0]       stat_bit_o
);

  localparam int CW    = 2 * ABITS + 6;
  localparam int CB    = (CW + 7) / 8;
  localparam int CBITS = CB * 8;
  localparam int CBW   = (CB > 1) ? $clog2(CB) : 1;
  localparam int SKW   = (SPARE_SKIP > 1) ? $clog2(SPARE_SKIP) : 1;

  ecc_phase_e         phase_q;
  logic               mode_q;
  logic [ABITS-1:0]   addr_q;
  logic [SECW-1:0]    sec_q;
  logic [SKW-1:0]     skip_q;
  logic [CBW-1:0]     cb_q;
  logic [CBITS-1:0]   calc_q [SECTORS];
  logic [CBITS-9:0]   codebuf_q;
  logic               stat_v_q;
  logic [1:0]         stat_c_q;
  logic [SECW-1:0]    stat_s_q;
  logic [ABITS-1:0]   stat_o_q;
  logic [2:0]         stat_b_q;

  logic               take, give, sect_last, page_last, cb_last, skip_last;
  logic               acc_en, acc_clr;
  logic [CW-1:0]      acc_next;
  logic [CBITS-1:0]   stored_full;
  logic [CW-1:0]      syn;
  logic [1:0]         cls_stat;
  logic [ABITS-1:0]   cls_off;
  logic [2:0]         cls_bit;

  // ---------------- handshake ----------------
  assign in_ready_o  = !start_i &&
                       (phase_q == PH_DATA || phase_q == PH_SKIP || phase_q == PH_CODE);
  assign out_valid_o = (phase_q == PH_EMIT);
  assign out_data_o  = calc_q[sec_q][{cb_q, 3'b000} +: 8];
  assign take        = in_valid_i && in_ready_o;
  assign give        = out_valid_o && out_ready_i;

  assign sect_last = (addr_q == ABITS'(SECTOR_BYTES - 1));
  assign page_last = (sec_q  == SECW'(SECTORS - 1));
  assign cb_last   = (cb_q   == CBW'(CB - 1));
  assign skip_last = (skip_q == SKW'(SPARE_SKIP - 1));

  // ---------------- parity accumulation ----------------
  assign acc_en  = take && (phase_q == PH_DATA);
  assign acc_clr = start_i || (acc_en && sect_last);

  ecc_sector_acc #(.ABITS(ABITS), .CW(CW)) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (acc_clr),
    .en_i       (acc_en),
    .addr_i     (addr_q),
    .data_i     (in_data_i),
    .acc_next_o (acc_next)
  );

  // ---------------- syndrome on the last code byte of a sector ----------------
  assign stored_full = {in_data_i, codebuf_q};
  assign syn         = stored_full[CW-1:0] ^ calc_q[sec_q][CW-1:0];

  ecc_syn_classify #(.ABITS(ABITS), .CW(CW)) u_cls (
    .syn_i  (syn),
    .stat_o (cls_stat),
    .off_o  (cls_off),
    .bit_o  (cls_bit)
  );

  // ---------------- sequencing ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      mode_q    <= 1'b0;
      addr_q    <= '0;
      sec_q     <= '0;
      skip_q    <= '0;
      cb_q      <= '0;
      codebuf_q <= '0;
      stat_v_q  <= 1'b0;
      stat_c_q  <= '0;
      stat_s_q  <= '0;
      stat_o_q  <= '0;
      stat_b_q  <= '0;
      for (int s = 0; s < SECTORS; s++) calc_q[s] <= '0;
    end else begin
      stat_v_q <= 1'b0;
      if (start_i) begin
        phase_q   <= PH_DATA;
        mode_q    <= mode_i;
        addr_q    <= '0;
        sec_q     <= '0;
        skip_q    <= '0;
        cb_q      <= '0;
        codebuf_q <= '0;
      end else begin
        unique case (phase_q)
          PH_DATA: if (take) begin
            addr_q <= addr_q + ABITS'(1);
            if (sect_last) begin
              calc_q[sec_q] <= CBITS'(acc_next);
              if (page_last) begin
                sec_q   <= '0;
                phase_q <= !mode_q ? PH_EMIT :
                           (SPARE_SKIP > 0) ? PH_SKIP : PH_CODE;
              end else begin
                sec_q <= sec_q + SECW'(1);
              end
            end
          end
          PH_SKIP: if (take) begin
            if (skip_last) begin
              skip_q  <= '0;
              phase_q <= PH_CODE;
            end else begin
              skip_q <= skip_q + SKW'(1);
            end
          end
          PH_CODE: if (take) begin
            if (cb_last) begin
              cb_q     <= '0;
              stat_v_q <= 1'b1;
              stat_c_q <= cls_stat;
              stat_s_q <= sec_q;
              stat_o_q <= cls_off;
              stat_b_q <= cls_bit;
              if (page_last) begin
                sec_q   <= '0;
                phase_q <= PH_IDLE;
              end else begin
                sec_q <= sec_q + SECW'(1);
              end
            end else begin
              codebuf_q[{cb_q, 3'b000} +: 8] <= in_data_i;
              cb_q <= cb_q + CBW'(1);
            end
          end
          PH_EMIT: if (give) begin
            if (cb_last) begin
              cb_q <= '0;
              if (page_last) begin
                sec_q   <= '0;
                phase_q <= PH_IDLE;
              end else begin
                sec_q <= sec_q + SECW'(1);
              end
            end else begin
              cb_q <= cb_q + CBW'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign stat_valid_o  = stat_v_q;
  assign stat_code_o   = stat_c_q;
  assign stat_sector_o = stat_s_q;
  assign stat_offset_o = stat_o_q;
  assign stat_bit_o    = stat_b_q;

  // ---------------- assertions ----------------
  // R3
  emit_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid_o) |-> $past(in_valid_i && in_ready_o));

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i && !start_i) |=> (out_valid_o && $stable(out_data_o)));

  // R9
  stat_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid_o |-> mode_q);

  // R9
  stat_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid_o |=> !stat_valid_o);

  // R9
  stat_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid_o |-> $past(in_valid_i && in_ready_o));

  // R12
  stat_loc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid_o && stat_code_o != 2'd1) |-> (stat_offset_o == '0 && stat_bit_o == '0));

endmodule

// File: tb/ecc_nand_page_hamming_tb.sv
`timescale 1ns/1ps
module ecc_nand_page_hamming_tb;

  localparam int SB  = 8;
  localparam int NS  = 4;
  localparam int SK  = 2;
  localparam int DB  = SB * NS;          // 32 data bytes
  localparam int CBY = 2;                // code bytes per sector (12-bit code)
  localparam int PG  = DB + SK + NS * CBY;
  localparam int CO  = DB + SK;          // first code byte in the image

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, mode_i = 1'b0;
  logic       in_valid_i = 1'b0;
  logic [7:0] in_data_i = '0;
  logic       in_ready_o, out_valid_o, out_ready_i;
  logic [7:0] out_data_o;
  logic       stat_valid_o;
  logic [1:0] stat_code_o;
  logic [1:0] stat_sector_o;
  logic [2:0] stat_offset_o;
  logic [2:0] stat_bit_o;

  ecc_nand_page_hamming #(.SECTOR_BYTES(SB), .SECTORS(NS), .SPARE_SKIP(SK)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_ready_o(in_ready_o),
    .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_ready_i(out_ready_i),
    .stat_valid_o(stat_valid_o), .stat_code_o(stat_code_o), .stat_sector_o(stat_sector_o),
    .stat_offset_o(stat_offset_o), .stat_bit_o(stat_bit_o)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [7:0] img [PG];

  int st_cnt = 0;
  int st_sec [8], st_code [8], st_off [8], st_bit [8];
  int ob_cnt = 0;
  logic [7:0] ob [16];
  int hold_err = 0, dual_err = 0, start_rdy_err = 0;
  int rdy_mode = 0, rdy_cnt = 0;
  logic prev_stall = 1'b0;
  logic [7:0] prev_d = '0;
  logic start_at_edge = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Sink ready pattern, changed just after the edge.
  always @(posedge clk) begin
    #1;
    rdy_cnt++;
    case (rdy_mode)
      0: out_ready_i = 1'b1;
      1: out_ready_i = (rdy_cnt % 3) != 0;
      default: out_ready_i = 1'b0;
    endcase
  end

  always @(posedge clk) start_at_edge <= start_i;

  // Monitors sample mid-cycle, after the ready update and before the next negedge.
  always @(posedge clk) begin
    #2;
    if (stat_valid_o && st_cnt < 8) begin
      st_sec[st_cnt]  = stat_sector_o;
      st_code[st_cnt] = stat_code_o;
      st_off[st_cnt]  = stat_offset_o;
      st_bit[st_cnt]  = stat_bit_o;
      st_cnt++;
    end
    if (prev_stall && !start_at_edge && !(out_valid_o && out_data_o == prev_d)) hold_err++;
    prev_stall = out_valid_o && !out_ready_i;
    prev_d     = out_data_o;
    if (out_valid_o && out_ready_i && ob_cnt < 16) begin
      ob[ob_cnt] = out_data_o;
      ob_cnt++;
    end
    if (out_valid_o && in_ready_o) dual_err++;
  end

  // Reference code from R2.
  function automatic logic [15:0] ref_code(input int s);
    logic [15:0] r = '0;
    for (int a = 0; a < SB; a++)
      for (int b = 0; b < 8; b++)
        if (img[s*SB + a][b]) begin
          for (int j = 0; j < 3; j++) r[2*j + ((a >> j) & 1)] ^= 1'b1;
          for (int c = 0; c < 3; c++) r[6 + 2*c + ((b >> c) & 1)] ^= 1'b1;
        end
    return r;
  endfunction

  task automatic build_page(input int seed);
    for (int i = 0; i < DB; i++) img[i] = 8'(i * 37 + seed * 11 + 5);
    img[DB]   = 8'(seed * 3);
    img[DB+1] = 8'(~seed);
    for (int s = 0; s < NS; s++) begin
      logic [15:0] c;
      c = ref_code(s);
      img[CO + CBY*s]     = c[7:0];
      img[CO + CBY*s + 1] = c[15:8];
    end
  endtask

  task automatic flip(input int f);
    if (f >= 0) img[f / 8][f % 8] = ~img[f / 8][f % 8];
  endtask

  task automatic do_start(input logic m);
    @(negedge clk);
    start_i = 1'b1;
    mode_i  = m;
    st_cnt  = 0;
    ob_cnt  = 0;
    #1;
    if (in_ready_o) start_rdy_err++;      // R11
    @(negedge clk);
    start_i    = 1'b0;
    in_valid_i = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    in_valid_i = 1'b1;
    in_data_i  = b;
    #1;
    while (!in_ready_o) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic idle_in();
    @(negedge clk);
    in_valid_i = 1'b0;
  endtask

  task automatic send_bytes(input int n);
    for (int i = 0; i < n; i++) begin
      if (i % 11 == 10) begin
        @(negedge clk);
        in_valid_i = 1'b0;
      end
      push(img[i]);
    end
  endtask

  task automatic check_page();
    do_start(1'b1);
    send_bytes(PG);
    idle_in();
    repeat (5) @(negedge clk);
  endtask

  // Compare the four statuses; sector sb gets code cb (with off/bt when fixable), others clean.
  task automatic judge(input string req, input int sb, input int cb, input int off, input int bt);
    longint act = 0, exp = 0;
    for (int s = 0; s < NS; s++) begin
      int ec, eo, eb;
      ec = (s == sb) ? cb : 0;
      eo = (s == sb && cb == 1) ? off : 0;
      eb = (s == sb && cb == 1) ? bt : 0;
      exp = (exp << 12) | longint'((s << 9) | (ec << 6) | (eo << 3) | eb);
      if (s < st_cnt)
        act = (act << 12) | longint'((st_sec[s] << 9) | (st_code[s] << 6) | (st_off[s] << 3) | st_bit[s]);
      else
        act = (act << 12) | 64'hFFF;
    end
    chk(st_cnt == NS && act == exp, req, act, exp);
  endtask

  task automatic encode_page(input int seed, input int rm);
    rdy_mode = rm;
    build_page(seed);
    do_start(1'b0);
    send_bytes(DB);
    idle_in();
    for (int w = 0; w < 100 && ob_cnt < NS * CBY; w++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(ob_cnt == NS * CBY, "R3 code byte count", ob_cnt, NS * CBY);
    for (int k = 0; k < NS * CBY; k++)
      chk(ob[k] == img[CO + k], "R2 R3 code byte", ob[k], img[CO + k]);
    chk(st_cnt == 0, "R9 no status in encode", st_cnt, 0);
    chk(!out_valid_o, "R3 idle after emission", out_valid_o, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!in_ready_o,   "R1 in_ready after reset",   in_ready_o, 0);
    chk(!out_valid_o,  "R1 out_valid after reset",  out_valid_o, 0);
    chk(!stat_valid_o, "R1 stat_valid after reset", stat_valid_o, 0);

    // Encode: continuous and stalled sinks.
    encode_page(1, 0);
    encode_page(7, 1);
    encode_page(22, 1);

    // Clean check pages, with different spare content (R4, R5).
    for (int p = 0; p < 4; p++) begin
      rdy_mode = 0;
      build_page(p + 40);
      img[DB] = 8'(p * 85);
      img[DB+1] = 8'(~(p * 85));
      check_page();
      judge("R4 R5 clean page", -1, 0, 0, 0);
    end

    // Every single data bit (R6).
    for (int f = 0; f < DB * 8; f++) begin
      build_page(f);
      flip(f);
      check_page();
      judge("R6 single data bit", f / (SB * 8), 1, (f % (SB * 8)) / 8, f % 8);
    end

    // Every stored code bit, including the pad bits (R7, R2).
    for (int s = 0; s < NS; s++)
      for (int cbit = 0; cbit < CBY * 8; cbit++) begin
        build_page(s * 16 + cbit + 3);
        flip((CO + CBY * s) * 8 + cbit);
        check_page();
        if (cbit < 12) judge("R7 single code bit", s, 2, 0, 0);
        else           judge("R2 pad bit ignored", -1, 0, 0, 0);
      end

    // Every pair of data bits inside sector 1 (R8, R12).
    for (int i = 0; i < SB * 8; i++)
      for (int j = i + 1; j < SB * 8; j++) begin
        build_page(i + j);
        flip(SB * 8 + i);
        flip(SB * 8 + j);
        check_page();
        judge("R8 R12 double data", 1, 3, 0, 0);
      end

    // Data bit plus code bit in sector 2 (R8).
    for (int d = 0; d < 8; d++)
      for (int cbit = 0; cbit < 12; cbit++) begin
        build_page(d * 12 + cbit);
        flip(2 * SB * 8 + d * 9 % (SB * 8));
        flip((CO + CBY * 2) * 8 + cbit);
        check_page();
        judge("R8 data plus code", 2, 3, 0, 0);
      end

    // Restart in the middle of a check page (R10).
    rdy_mode = 0;
    build_page(90);
    flip(5);
    do_start(1'b1);
    send_bytes(13);
    build_page(91);
    check_page();
    judge("R10 mid-page restart", -1, 0, 0, 0);

    // Restart while an emitted byte is stalled (R10, R11).
    rdy_mode = 2;
    build_page(92);
    do_start(1'b0);
    send_bytes(DB);
    idle_in();
    repeat (3) @(negedge clk);
    chk(out_valid_o, "R11 stalled byte stays valid", out_valid_o, 1);
    chk(out_data_o == img[CO], "R11 stalled byte value", out_data_o, img[CO]);
    do_start(1'b1);
    chk(!out_valid_o, "R10 emission dropped on start", out_valid_o, 0);
    rdy_mode = 0;
    build_page(93);
    flip(200);
    send_bytes(PG);
    idle_in();
    repeat (5) @(negedge clk);
    judge("R10 page after restart", 3, 1, 1, 0);

    chk(hold_err == 0,      "R11 output hold",          hold_err, 0);
    chk(dual_err == 0,      "R11 no input during emit", dual_err, 0);
    chk(start_rdy_err == 0, "R11 ready low on start",   start_rdy_err, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule